// File: doc/BRIEF.md
# Submission/Completion Ring DMA Channel Controller

This block is the per-channel control plane of a memory-to-memory copy engine that takes its work from a submission ring and reports results into a completion ring. Software programs the ring base addresses and sizes through a 32-bit register window of 0x100 bytes, then rings the doorbell by moving the submission tail. The block keeps the consumer position of the submission ring and the producer position of the completion ring. From these it decides whether the engine may fetch another entry.

A channel state machine reacts to enable, pause, queue reset, engine completions and engine errors. Its current state can be read back as a 4-bit code. Completion, error and completion-overflow events are collected in a write-1-to-clear status register. A mask register gates them onto a single interrupt line. Moving descriptors to and from memory belongs to the engine and is outside this block.

Top module: `qp_chan_ctrl`

## Requirements
- R1: After reset the control word, all ring pointers and the interrupt status are 0, both depth registers read 0x3FF, the mask reads 0x1FFF (all masked), the state code reads 0 (idle), and work_pend_o and irq_o are low.
- R2: Register offsets are: submission base low/high 0x00/0x04, submission depth 0x08, submission tail 0x0C, completion base low/high 0x10/0x14, completion depth 0x18, completion head 0x1C, control 0x20 (bit 0 enable, bit 4 pause), reset control 0x24 (bit 0 queue reset, always reads 0), state 0x30, interrupt status 0x40, interrupt mask 0x44. A read returns its data one cycle after the request. Unmapped offsets read 0. The submission base is driven on sq_base_o as {high, low}.
- R3: A depth register holds the ring size minus one. The submission head and the completion tail step from that value back to 0.
- R4: work_pend_o is high only in the RUN state while enabled, not paused, with the submission head different from the tail and with room in the completion ring. The completion ring is full when the tail's successor equals the head.
- R5: eng_fetch_i advances the submission head only while work_pend_o is high. Otherwise it is ignored.
- R6: State codes are IDLE=0, RUN=1, CPL=2, PAUSE=3, HALT=4, ABORT=5, WAIT=6, BUFFCLR=7. IDLE moves to RUN when the channel is enabled, unpaused and has pending work. RUN moves to CPL on eng_cpl_i, and CPL returns to IDLE one cycle later.
- R7: Setting pause in RUN moves the channel to PAUSE and freezes the submission head. Releasing pause returns it to RUN if enabled, or to IDLE otherwise.
- R8: Clearing enable in RUN (without pause) moves the channel to WAIT. It stays there until the engine reports a completion, then goes to IDLE.
- R9: Writing 1 to the queue reset bit moves the channel to BUFFCLR on the next cycle and to IDLE on the cycle after. It also clears the submission tail, the completion head, the submission head and the completion tail.
- R10: eng_err_i in RUN or WAIT moves the channel to ABORT and then to HALT. HALT holds until a queue reset. Every engine error sets interrupt status bit 1.
- R11: Interrupt status bit 0 is set by an accepted completion. Writing 1 to a status bit clears it, and a new event in the same cycle wins over the clear. irq_o is high when any unmasked status bit is set.
- R12: A completion that arrives while the completion ring is full is dropped. The completion tail is unchanged, status bit 2 is set, and bit 0 is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Byte offset in the channel window |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after a read request |
| eng_fetch_i | input | 1 | Engine takes one submission entry |
| eng_cpl_i | input | 1 | Engine finished a task and posts a completion |
| eng_err_i | input | 1 | Engine reports a failed task |
| work_pend_o | output | 1 | Engine may fetch a submission entry |
| sq_base_o | output | 64 | Submission ring base address |
| cq_base_o | output | 64 | Completion ring base address |
| sq_head_o | output | PTR_W | Submission ring consumer index |
| cq_tail_o | output | PTR_W | Completion ring producer index |
| irq_o | output | 1 | Channel interrupt |

## Verification
A register write takes effect at the clock edge that samples it. The state machine responds one edge later, so a state read issued right after a doorbell, control or mask write would still return the old code. The bench inserts one idle cycle before reading the state in those cases. A queue reset, an engine completion and an engine error change the state at the edge that samples them. The bench therefore reads the state in the very next cycle, which is how the single-cycle CPL, BUFFCLR and ABORT codes are caught. Pointer and interrupt outputs are registered or derived from registers, and they are sampled at the falling edge after the stimulus.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_RUN     = 4'd1,
    ST_CPL     = 4'd2,
    ST_PAUSE   = 4'd3,
    ST_HALT    = 4'd4,
    ST_ABORT   = 4'd5,
    ST_WAIT    = 4'd6,
    ST_BUFFCLR = 4'd7
  } qpc_state_e;

  localparam logic [7:0] OFS_SQ_BASE_LO = 8'h00;
  localparam logic [7:0] OFS_SQ_BASE_HI = 8'h04;
  localparam logic [7:0] OFS_SQ_DEPTH   = 8'h08;
  localparam logic [7:0] OFS_SQ_TAIL    = 8'h0C;
  localparam logic [7:0] OFS_CQ_BASE_LO = 8'h10;
  localparam logic [7:0] OFS_CQ_BASE_HI = 8'h14;
  localparam logic [7:0] OFS_CQ_DEPTH   = 8'h18;
  localparam logic [7:0] OFS_CQ_HEAD    = 8'h1C;
  localparam logic [7:0] OFS_CTRL       = 8'h20;
  localparam logic [7:0] OFS_QRST       = 8'h24;
  localparam logic [7:0] OFS_STATE      = 8'h30;
  localparam logic [7:0] OFS_IRQ_STS    = 8'h40;
  localparam logic [7:0] OFS_IRQ_MSK    = 8'h44;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_PAUSE_BIT = 4;
  localparam int QRST_BIT       = 0;

  localparam int IRQ_W   = 13;
  localparam int IRQ_CPL = 0;
  localparam int IRQ_ERR = 1;
  localparam int IRQ_OVF = 2;

endpackage

// File: rtl/qpc_ring_ptr.sv
module qpc_ring_ptr #(
  parameter int PTR_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [PTR_W-1:0] last_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] nxt_o
);

  logic [PTR_W-1:0] ptr_q;

  assign nxt_o = (ptr_q == last_i) ? '0 : ptr_q + PTR_W'(1);
  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (clr_i)  ptr_q <= '0;
    else if (adv_i)  ptr_q <= nxt_o;
  end

endmodule

// File: rtl/qpc_chan_fsm.sv
module qpc_chan_fsm
  import qpc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       pause_i,
  input  logic       qrst_i,
  input  logic       pend_i,
  input  logic       cpl_i,
  input  logic       err_i,
  output qpc_state_e state_o
);

  qpc_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (qrst_i) begin
      st_d = ST_BUFFCLR;
    end else begin
      case (st_q)
        ST_IDLE:    if (en_i && !pause_i && pend_i) st_d = ST_RUN;
        ST_RUN: begin
          if (err_i)        st_d = ST_ABORT;
          else if (cpl_i)   st_d = ST_CPL;
          else if (pause_i) st_d = ST_PAUSE;
          else if (!en_i)   st_d = ST_WAIT;
        end
        ST_CPL:     st_d = ST_IDLE;
        ST_PAUSE:   if (!pause_i) st_d = en_i ? ST_RUN : ST_IDLE;
        ST_WAIT: begin
          if (err_i)      st_d = ST_ABORT;
          else if (cpl_i) st_d = ST_IDLE;
        end
        ST_ABORT:   st_d = ST_HALT;
        ST_HALT:    st_d = ST_HALT;
        ST_BUFFCLR: st_d = ST_IDLE;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

endmodule

// File: rtl/qpc_irq_ctrl.sv
module qpc_irq_ctrl #(
  parameter int IRQ_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] set_i,
  input  logic             sts_we_i,
  input  logic             msk_we_i,
  input  logic [IRQ_W-1:0] wdata_i,
  output logic [IRQ_W-1:0] sts_o,
  output logic [IRQ_W-1:0] msk_o,
  output logic             irq_o
);

  logic [IRQ_W-1:0] sts_q, msk_q, clr;

  assign clr = sts_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      msk_q <= '1;
    end else begin
      sts_q <= (sts_q & ~clr) | set_i;
      if (msk_we_i) msk_q <= wdata_i;
    end
  end

  assign sts_o = sts_q;
  assign msk_o = msk_q;
  assign irq_o = |(sts_q & ~msk_q);

endmodule

// File: rtl/qp_chan_ctrl.sv
module qp_chan_ctrl
  import qpc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PTR_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              eng_fetch_i,
  input  logic              eng_cpl_i,
  input  logic              eng_err_i,
  output logic              work_pend_o,
  output logic [63:0]       sq_base_o,
  output logic [63:0]       cq_base_o,
  output logic [PTR_W-1:0]  sq_head_o,
  output logic [PTR_W-1:0]  cq_tail_o,
  output logic              irq_o
);

  localparam int AW = (ADDR_W > 8) ? ADDR_W : 8;

  logic [AW-1:0]    addr;
  logic             wr, rd;
  logic [31:0]      sq_base_lo_q, sq_base_hi_q, cq_base_lo_q, cq_base_hi_q;
  logic [PTR_W-1:0] sq_depth_q, cq_depth_q, sq_tail_q, cq_head_q;
  logic             ctrl_en_q, ctrl_pause_q;
  logic             qrst;
  logic [PTR_W-1:0] sq_head, sq_head_nxt, cq_tail, cq_tail_nxt;
  logic             sq_nonempty, cq_space, pend, fetch_ok, cpl_ok;
  qpc_state_e       fsm_state;
  logic [IRQ_W-1:0] irq_set, irq_sts, irq_msk;
  logic [31:0]      rd_mux, rdata_q;

  assign addr = AW'(reg_addr_i);
  assign wr   = reg_req_i && reg_we_i;
  assign rd   = reg_req_i && !reg_we_i;

  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] ofs);
    return a == AW'(ofs);
  endfunction

  assign qrst = wr && hit(addr, OFS_QRST) && reg_wdata_i[QRST_BIT];

  // software-owned registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_base_lo_q <= '0;
      sq_base_hi_q <= '0;
      cq_base_lo_q <= '0;
      cq_base_hi_q <= '0;
      sq_depth_q   <= '1;
      cq_depth_q   <= '1;
      sq_tail_q    <= '0;
      cq_head_q    <= '0;
      ctrl_en_q    <= 1'b0;
      ctrl_pause_q <= 1'b0;
    end else if (qrst) begin
      sq_tail_q <= '0;
      cq_head_q <= '0;
    end else if (wr) begin
      if (hit(addr, OFS_SQ_BASE_LO)) sq_base_lo_q <= reg_wdata_i;
      if (hit(addr, OFS_SQ_BASE_HI)) sq_base_hi_q <= reg_wdata_i;
      if (hit(addr, OFS_CQ_BASE_LO)) cq_base_lo_q <= reg_wdata_i;
      if (hit(addr, OFS_CQ_BASE_HI)) cq_base_hi_q <= reg_wdata_i;
      if (hit(addr, OFS_SQ_DEPTH))   sq_depth_q   <= reg_wdata_i[PTR_W-1:0];
      if (hit(addr, OFS_CQ_DEPTH))   cq_depth_q   <= reg_wdata_i[PTR_W-1:0];
      if (hit(addr, OFS_SQ_TAIL))    sq_tail_q    <= reg_wdata_i[PTR_W-1:0];
      if (hit(addr, OFS_CQ_HEAD))    cq_head_q    <= reg_wdata_i[PTR_W-1:0];
      if (hit(addr, OFS_CTRL)) begin
        ctrl_en_q    <= reg_wdata_i[CTRL_EN_BIT];
        ctrl_pause_q <= reg_wdata_i[CTRL_PAUSE_BIT];
      end
    end
  end

  // engine-owned ring positions
  qpc_ring_ptr #(.PTR_W(PTR_W)) u_sq_head (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (qrst),
    .adv_i  (fetch_ok),
    .last_i (sq_depth_q),
    .ptr_o  (sq_head),
    .nxt_o  (sq_head_nxt)
  );

  qpc_ring_ptr #(.PTR_W(PTR_W)) u_cq_tail (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (qrst),
    .adv_i  (cpl_ok),
    .last_i (cq_depth_q),
    .ptr_o  (cq_tail),
    .nxt_o  (cq_tail_nxt)
  );

  assign sq_nonempty = sq_head != sq_tail_q;
  assign cq_space    = cq_tail_nxt != cq_head_q;
  assign pend        = sq_nonempty && cq_space;
  assign work_pend_o = (fsm_state == ST_RUN) && ctrl_en_q && !ctrl_pause_q && pend;
  assign fetch_ok    = eng_fetch_i && work_pend_o && !qrst;
  assign cpl_ok      = eng_cpl_i && cq_space && !qrst;

  qpc_chan_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl_en_q),
    .pause_i (ctrl_pause_q),
    .qrst_i  (qrst),
    .pend_i  (pend),
    .cpl_i   (eng_cpl_i),
    .err_i   (eng_err_i),
    .state_o (fsm_state)
  );

  always_comb begin
    irq_set          = '0;
    irq_set[IRQ_CPL] = cpl_ok;
    irq_set[IRQ_ERR] = eng_err_i;
    irq_set[IRQ_OVF] = eng_cpl_i && !cq_space;
  end

  qpc_irq_ctrl #(.IRQ_W(IRQ_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (irq_set),
    .sts_we_i (wr && hit(addr, OFS_IRQ_STS)),
    .msk_we_i (wr && hit(addr, OFS_IRQ_MSK)),
    .wdata_i  (reg_wdata_i[IRQ_W-1:0]),
    .sts_o    (irq_sts),
    .msk_o    (irq_msk),
    .irq_o    (irq_o)
  );

  // read path, one cycle latency
  always_comb begin
    rd_mux = '0;
    if      (hit(addr, OFS_SQ_BASE_LO)) rd_mux = sq_base_lo_q;
    else if (hit(addr, OFS_SQ_BASE_HI)) rd_mux = sq_base_hi_q;
    else if (hit(addr, OFS_SQ_DEPTH))   rd_mux = 32'(sq_depth_q);
    else if (hit(addr, OFS_SQ_TAIL))    rd_mux = 32'(sq_tail_q);
    else if (hit(addr, OFS_CQ_BASE_LO)) rd_mux = cq_base_lo_q;
    else if (hit(addr, OFS_CQ_BASE_HI)) rd_mux = cq_base_hi_q;
    else if (hit(addr, OFS_CQ_DEPTH))   rd_mux = 32'(cq_depth_q);
    else if (hit(addr, OFS_CQ_HEAD))    rd_mux = 32'(cq_head_q);
    else if (hit(addr, OFS_CTRL)) begin
      rd_mux[CTRL_EN_BIT]    = ctrl_en_q;
      rd_mux[CTRL_PAUSE_BIT] = ctrl_pause_q;
    end
    else if (hit(addr, OFS_STATE))      rd_mux = 32'(fsm_state);
    else if (hit(addr, OFS_IRQ_STS))    rd_mux = 32'(irq_sts);
    else if (hit(addr, OFS_IRQ_MSK))    rd_mux = 32'(irq_msk);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign sq_base_o   = {sq_base_hi_q, sq_base_lo_q};
  assign cq_base_o   = {cq_base_hi_q, cq_base_lo_q};
  assign sq_head_o   = sq_head;
  assign cq_tail_o   = cq_tail;

endmodule

// File: rtl/qpc_chan_sva.sv
module qpc_chan_sva
  import qpc_pkg::*;
#(
  parameter int PTR_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             qrst,
  input qpc_state_e       fsm_state,
  input logic             ctrl_en_q,
  input logic             ctrl_pause_q,
  input logic             eng_cpl_i,
  input logic             eng_err_i,
  input logic             cq_space,
  input logic [PTR_W-1:0] cq_tail,
  input logic [12:0]      irq_sts
);

  assert_qrst_enters_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qrst |=> fsm_state == ST_BUFFCLR);

  assert_clear_to_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_state == ST_BUFFCLR && !qrst) |=> fsm_state == ST_IDLE);

  assert_halt_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_state == ST_HALT && !qrst) |=> fsm_state == ST_HALT);

  assert_cpl_sets_status_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_cpl_i && cq_space && !qrst) |=> irq_sts[IRQ_CPL]);

  assert_full_drops_cpl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_cpl_i && !cq_space && !qrst) |=> (cq_tail == $past(cq_tail)) && irq_sts[IRQ_OVF]);

  assert_pause_leaves_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_state == ST_RUN && ctrl_pause_q && !eng_cpl_i && !eng_err_i && !qrst)
      |=> fsm_state == ST_PAUSE);

  assert_disable_waits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_state == ST_RUN && !ctrl_en_q && !ctrl_pause_q && !eng_cpl_i && !eng_err_i && !qrst)
      |=> fsm_state == ST_WAIT);

endmodule

bind qp_chan_ctrl qpc_chan_sva #(.PTR_W(PTR_W)) u_qpc_chan_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .qrst         (qrst),
  .fsm_state    (fsm_state),
  .ctrl_en_q    (ctrl_en_q),
  .ctrl_pause_q (ctrl_pause_q),
  .eng_cpl_i    (eng_cpl_i),
  .eng_err_i    (eng_err_i),
  .cq_space     (cq_space),
  .cq_tail      (cq_tail),
  .irq_sts      (irq_sts)
);

// File: tb/qp_chan_ctrl_bench.sv
`timescale 1ns/1ps
module qp_chan_ctrl_bench;

  localparam int PW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          fetch = 1'b0, cpl = 1'b0, err = 1'b0;
  logic          pend;
  logic [63:0]   sq_base, cq_base;
  logic [PW-1:0] sq_head, cq_tail;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qp_chan_ctrl #(.ADDR_W(8), .PTR_W(PW)) u_qp_chan_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .eng_fetch_i(fetch), .eng_cpl_i(cpl), .eng_err_i(err),
    .work_pend_o(pend), .sq_base_o(sq_base), .cq_base_o(cq_base),
    .sq_head_o(sq_head), .cq_tail_o(cq_tail), .irq_o(irq)
  );

  localparam logic [7:0] A_SQB_LO = 8'h00, A_SQB_HI = 8'h04, A_SQD = 8'h08, A_SQT = 8'h0C;
  localparam logic [7:0] A_CQB_LO = 8'h10, A_CQD = 8'h18, A_CQH = 8'h1C;
  localparam logic [7:0] A_CTL = 8'h20, A_RST = 8'h24, A_ST = 8'h30, A_STS = 8'h40, A_MSK = 8'h44;

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string r, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(r, 64'(d), 64'(exp));
  endtask

  task automatic pulse_fetch(); fetch = 1'b1; @(negedge clk); fetch = 1'b0; endtask
  task automatic pulse_cpl();   cpl = 1'b1;   @(negedge clk); cpl = 1'b0;   endtask
  task automatic pulse_err();   err = 1'b1;   @(negedge clk); err = 1'b0;   endtask

  task automatic t_reset();
    rd_chk("R1 mask", A_MSK, 32'h1FFF);
    rd_chk("R1 state", A_ST, 32'd0);
    rd_chk("R1 ctrl", A_CTL, 32'd0);
    rd_chk("R1 depth", A_SQD, 32'h3FF);
    rd_chk("R1 sts", A_STS, 32'd0);
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 pend", 64'(pend), 64'd0);
    check("R1 sq_head", 64'(sq_head), 64'd0);
  endtask

  task automatic t_regs();
    wr(A_SQB_LO, 32'hDEAD_BEEF);
    wr(A_SQB_HI, 32'h0000_0001);
    wr(A_CQB_LO, 32'h1234_5670);
    check("R2 sq_base_o", sq_base, 64'h1_DEAD_BEEF);
    rd_chk("R2 cq base lo", A_CQB_LO, 32'h1234_5670);
    rd_chk("R2 unmapped", 8'h2C, 32'd0);
    rd_chk("R2 qrst reads 0", A_RST, 32'd0);
  endtask

  task automatic t_run();
    wr(A_SQD, 32'd3);
    wr(A_CQD, 32'd3);
    wr(A_MSK, 32'd0);
    wr(A_CTL, 32'h1);
    idle(1);
    rd_chk("R6 idle without work", A_ST, 32'd0);
    wr(A_SQT, 32'd2);
    idle(1);
    rd_chk("R6 run", A_ST, 32'd1);
    check("R4 pend high", 64'(pend), 64'd1);
    pulse_fetch();
    pulse_fetch();
    check("R5 head advanced", 64'(sq_head), 64'd2);
    check("R4 pend low when empty", 64'(pend), 64'd0);
    pulse_fetch();
    check("R5 fetch ignored", 64'(sq_head), 64'd2);
    pulse_cpl();
    rd_chk("R6 cpl state", A_ST, 32'd2);
    check("R6 cq tail", 64'(cq_tail), 64'd1);
    check("R11 irq set", 64'(irq), 64'd1);
    rd_chk("R6 back to idle", A_ST, 32'd0);
    rd_chk("R11 sts bit0", A_STS, 32'h1);
    wr(A_STS, 32'h1);
    check("R11 w1c irq", 64'(irq), 64'd0);
    rd_chk("R11 w1c sts", A_STS, 32'h0);
  endtask

  task automatic t_mask();
    wr(A_MSK, 32'h1FFF);
    pulse_cpl();
    check("R11 masked irq", 64'(irq), 64'd0);
    rd_chk("R11 masked sts", A_STS, 32'h1);
    wr(A_MSK, 32'h0);
    check("R11 unmask irq", 64'(irq), 64'd1);
    wr(A_STS, 32'h1);
    check("R11 cq tail 2", 64'(cq_tail), 64'd2);
  endtask

  task automatic t_wrap();
    wr(A_SQT, 32'd0);
    idle(1);
    check("R4 pend after doorbell", 64'(pend), 64'd1);
    pulse_fetch();
    check("R3 head at last", 64'(sq_head), 64'd3);
    pulse_fetch();
    check("R3 head wraps", 64'(sq_head), 64'd0);
    pulse_cpl();
    check("R3 cq tail 3", 64'(cq_tail), 64'd3);
    idle(1);
    wr(A_STS, 32'h1);
  endtask

  task automatic t_cqfull();
    wr(A_SQT, 32'd1);
    idle(1);
    check("R4 pend low when cq full", 64'(pend), 64'd0);
    rd_chk("R4 idle when cq full", A_ST, 32'd0);
    pulse_cpl();
    check("R12 tail held", 64'(cq_tail), 64'd3);
    rd_chk("R12 overflow sts", A_STS, 32'h4);
    wr(A_STS, 32'h4);
  endtask

  task automatic t_pause();
    wr(A_CQH, 32'd3);
    idle(1);
    rd_chk("R6 run after cq space", A_ST, 32'd1);
    wr(A_CTL, 32'h11);
    idle(1);
    rd_chk("R7 paused", A_ST, 32'd3);
    check("R7 pend low", 64'(pend), 64'd0);
    pulse_fetch();
    check("R7 head frozen", 64'(sq_head), 64'd0);
    rd_chk("R2 ctrl readback", A_CTL, 32'h11);
    wr(A_CTL, 32'h1);
    idle(1);
    rd_chk("R7 resume", A_ST, 32'd1);
    check("R7 pend again", 64'(pend), 64'd1);
  endtask

  task automatic t_disable();
    wr(A_CTL, 32'h0);
    idle(1);
    rd_chk("R8 wait", A_ST, 32'd6);
    pulse_cpl();
    rd_chk("R8 idle after cpl", A_ST, 32'd0);
    check("R3 cq tail wraps", 64'(cq_tail), 64'd0);
    wr(A_STS, 32'h1);
  endtask

  task automatic t_error();
    wr(A_CTL, 32'h1);
    idle(1);
    rd_chk("R10 run before err", A_ST, 32'd1);
    pulse_err();
    rd_chk("R10 abort", A_ST, 32'd5);
    rd_chk("R10 halt", A_ST, 32'd4);
    rd_chk("R10 err sts", A_STS, 32'h2);
    idle(3);
    rd_chk("R10 halt holds", A_ST, 32'd4);
  endtask

  task automatic t_qreset();
    wr(A_RST, 32'h1);
    rd_chk("R9 buffclr", A_ST, 32'd7);
    rd_chk("R9 idle", A_ST, 32'd0);
    rd_chk("R9 sq tail cleared", A_SQT, 32'd0);
    rd_chk("R9 cq head cleared", A_CQH, 32'd0);
    check("R9 sq head cleared", 64'(sq_head), 64'd0);
    check("R9 cq tail cleared", 64'(cq_tail), 64'd0);
    wr(A_SQT, 32'd1);
    idle(1);
    rd_chk("R9 resumes run", A_ST, 32'd1);
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_regs();
    t_run();
    t_mask();
    t_wrap();
    t_cqfull();
    t_pause();
    t_disable();
    t_error();
    t_qreset();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule